// File: doc/BRIEF.md
# Cascaded Fixed-Priority Interrupt Controller

Two identical eight-input interrupt units form a master and a slave. Together they present fifteen request sources to a processor through a single interrupt output. Request lines 0, 1 and 3 to 7 go to the master. Lines 8 to 15 go to the slave, which is reached through the master's input 2. Each unit latches rising edges, applies its own per-input mask, and keeps track of which levels are in service. A unit raises its request only when a pending, unmasked input has higher priority than its highest in-service level.

The processor acknowledges an interrupt with two strobes on `inta_i`. The first strobe freezes arbitration. It marks the winner as in service, and it drives the winning master level on the three cascade-select outputs until the second strobe. On the second strobe the block drives an 8-bit vector: a 5-bit base for the owning unit, followed by the 3-bit level. Software ends service by sending an end-of-interrupt that names a unit and a level. A slave source needs an end-of-interrupt to the slave and another to the master level 2.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A request is latched on a rising edge of its line. Holding a line high yields exactly one request. Line 2 of `irq_i` has no effect, because that master input is driven by the slave.
- R2: Effective priority from highest to lowest is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. Between the two acknowledge strobes, `cas_o` carries the acknowledged master level, which is 2 for any slave source. At all other times `cas_o` is 0.
- R3: `mask_we_i` writes `mask_i` to the master mask (`mask_sel_i`=0) or to the slave mask (`mask_sel_i`=1). A mask bit of 1 blocks that input. A request latched while masked stays pending and is raised once the mask bit is cleared.
- R4: The first acknowledge strobe sets the winner's in-service bit and clears its pending bit. `vec_oe_o` stays low during the first strobe.
- R5: During the second strobe, `vec_oe_o` is high and `vec_o` = {base, level}. The master base is 5'h01, so master level n gives 8'h08+n. The slave base is 5'h0E, so slave input k gives 8'h70+k.
- R6: Source 9 (slave input 1) yields the same vector as master level 2, which is 8'h0A.
- R7: `int_o` is high only if an unmasked pending request has strictly higher priority than the highest in-service level of the same unit. A slave source in service occupies master level 2.
- R8: End-of-interrupt (`eoi_i`, with `eoi_slave_i` selecting the unit and `eoi_lvl_i` the level) clears that in-service bit. A slave source stays blocking at the master until master level 2 is also ended.
- R9: An acknowledge with no request gives vector 8'h0F and `cas_o`=7, and it sets no in-service bit.
- R10: After reset, `int_o`, `vec_oe_o` and `cas_o` are 0, and all masks are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines; [7:0] master, [15:8] slave, bit 2 unused |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 1 | Mask target: 0 master, 1 slave |
| mask_i | input | 8 | Mask value |
| inta_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_slave_i | input | 1 | End-of-interrupt target: 0 master, 1 slave |
| eoi_lvl_i | input | 3 | Level to end |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector pointer, valid while vec_oe_o is high |
| vec_oe_o | output | 1 | Vector drive enable (second strobe) |
| cas_o | output | 3 | Cascade select during the acknowledge cycle |

## Verification
The hardest situations to reach are nested states, where one source is already in service and a second request arrives. This matters most when a slave source holds master level 2 and a lower master line or a higher master line is raised. Directed sequences build those states on purpose: they acknowledge without ending, raise further lines, and then end service one unit at a time, checking `int_o` after each step. Randomly masked bursts that are drained in priority order cover the arbitration order and the masked-but-pending requests.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned UNIT_INPUTS = 8;
  localparam int unsigned LVL_W = $clog2(UNIT_INPUTS);
  localparam int unsigned BASE_W = 8 - LVL_W;
  localparam int unsigned CASC_SLOT = 2;

  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_WAIT = 1'b1
  } ack_state_e;
endpackage

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned N = 8,
  parameter int unsigned LW = $clog2(N),
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  input  logic [LW-1:0] eoi_lvl_i,
  output logic          req_o,
  output logic [LW-1:0] win_o,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0] irq_q, irr_q, imr_q, isr_q;
  logic [N-1:0] rise, irr_eff, pend, ack_set, eoi_clr;
  logic [LW-1:0] pend_top, isr_top;
  logic pend_any, isr_any;

  // level-sensitive inputs bypass the edge latch
  assign rise    = irq_i & ~irq_q & ~LEVEL_MASK;
  assign irr_eff = (irr_q & ~LEVEL_MASK) | (irq_i & LEVEL_MASK);
  assign pend    = irr_eff & ~imr_q;

  always_comb begin
    pend_any = 1'b0;
    pend_top = '0;
    isr_any  = 1'b0;
    isr_top  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pend_any = 1'b1;
        pend_top = LW'(i);
      end
      if (isr_q[i]) begin
        isr_any = 1'b1;
        isr_top = LW'(i);
      end
    end
  end

  assign req_o = pend_any && (!isr_any || (pend_top < isr_top));
  assign win_o = pend_top;
  assign isr_o = isr_q;

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (ack_i && req_o) ack_set[pend_top] = 1'b1;
    if (eoi_i) eoi_clr[eoi_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
      imr_q <= '0;
      isr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= (irr_q & ~ack_set) | rise;
      if (mask_we_i) imr_q <= mask_i;
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
    end
  end

  // R4
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> isr_q[$past(win_o)]);

  // R3
  ack_not_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |-> !imr_q[win_o]);

  // R7
  win_not_in_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !isr_q[win_o]);

  // R8
  eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(ack_i && req_o && (win_o == eoi_lvl_i))) |=> !isr_q[$past(eoi_lvl_i)]);
endmodule

// File: rtl/irq_vec_form.sv
module irq_vec_form
  import irq_cascade_pkg::*;
#(
  parameter logic [BASE_W-1:0] M_BASE = 5'h01,
  parameter logic [BASE_W-1:0] S_BASE = 5'h0E
) (
  input  logic             from_slave_i,
  input  logic [LVL_W-1:0] m_lvl_i,
  input  logic [LVL_W-1:0] s_lvl_i,
  output logic [7:0]       vec_o
);
  localparam logic [LVL_W-1:0] ALIAS_SRC = LVL_W'(1);
  localparam logic [LVL_W-1:0] ALIAS_DST = LVL_W'(CASC_SLOT);

  always_comb begin
    if (!from_slave_i)               vec_o = {M_BASE, m_lvl_i};
    else if (s_lvl_i == ALIAS_SRC)   vec_o = {M_BASE, ALIAS_DST};  // redirected slave input
    else                             vec_o = {S_BASE, s_lvl_i};
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter logic [BASE_W-1:0] M_BASE = 5'h01,
  parameter logic [BASE_W-1:0] S_BASE = 5'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       irq_i,
  input  logic              mask_we_i,
  input  logic              mask_sel_i,
  input  logic [7:0]        mask_i,
  input  logic              inta_i,
  input  logic              eoi_i,
  input  logic              eoi_slave_i,
  input  logic [LVL_W-1:0]  eoi_lvl_i,
  output logic              int_o,
  output logic [7:0]        vec_o,
  output logic              vec_oe_o,
  output logic [LVL_W-1:0]  cas_o
);
  localparam int unsigned N = UNIT_INPUTS;
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_SLOT;
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N - 1);

  ack_state_e st_q;
  logic m_req, s_req, m_ack, s_ack, first_ack;
  logic [LVL_W-1:0] m_win, s_win, lat_m_q, lat_s_q;
  logic lat_slave_q;
  logic [N-1:0] m_isr, s_isr, m_irq;
  logic [7:0] vec_f;

  assign m_irq = (irq_i[N-1:0] & ~CASC_BIT) | (s_req ? CASC_BIT : '0);

  assign first_ack = inta_i && (st_q == ACK_IDLE);
  assign m_ack = first_ack;
  assign s_ack = first_ack && m_req && (m_win == LVL_W'(CASC_SLOT));

  irq_unit #(.N(N), .LW(LVL_W), .LEVEL_MASK(CASC_BIT)) u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (m_irq),
    .mask_we_i (mask_we_i && !mask_sel_i),
    .mask_i    (mask_i),
    .ack_i     (m_ack),
    .eoi_i     (eoi_i && !eoi_slave_i),
    .eoi_lvl_i (eoi_lvl_i),
    .req_o     (m_req),
    .win_o     (m_win),
    .isr_o     (m_isr)
  );

  irq_unit #(.N(N), .LW(LVL_W), .LEVEL_MASK('0)) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i[2*N-1:N]),
    .mask_we_i (mask_we_i && mask_sel_i),
    .mask_i    (mask_i),
    .ack_i     (s_ack),
    .eoi_i     (eoi_i && eoi_slave_i),
    .eoi_lvl_i (eoi_lvl_i),
    .req_o     (s_req),
    .win_o     (s_win),
    .isr_o     (s_isr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ACK_IDLE;
      lat_m_q     <= '0;
      lat_s_q     <= '0;
      lat_slave_q <= 1'b0;
    end else if (inta_i) begin
      if (st_q == ACK_IDLE) begin
        st_q        <= ACK_WAIT;
        lat_m_q     <= m_req ? m_win : SPUR_LVL;
        lat_s_q     <= s_win;
        lat_slave_q <= s_ack;
      end else begin
        st_q <= ACK_IDLE;
      end
    end
  end

  irq_vec_form #(.M_BASE(M_BASE), .S_BASE(S_BASE)) u_vec (
    .from_slave_i (lat_slave_q),
    .m_lvl_i      (lat_m_q),
    .s_lvl_i      (lat_s_q),
    .vec_o        (vec_f)
  );

  assign int_o    = m_req;
  assign vec_oe_o = inta_i && (st_q == ACK_WAIT);
  assign vec_o    = vec_oe_o ? vec_f : 8'h00;
  assign cas_o    = (st_q == ACK_WAIT) ? lat_m_q : '0;

  // R2
  slave_needs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_isr & ~$past(s_isr)) != '0) |-> m_isr[CASC_SLOT]);

  // R9
  spur_no_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_ack && !m_req) |=> (m_isr == $past(m_isr)) && (s_isr == $past(s_isr)));
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  localparam logic [4:0] MB = 5'h01;
  localparam logic [4:0] SB = 5'h0E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic mask_we = 0, mask_sel = 0, inta = 0, eoi = 0, eoi_slave = 0;
  logic [7:0] mask_v = '0;
  logic [2:0] eoi_lvl = '0;
  logic int_w, vec_oe;
  logic [7:0] vec;
  logic [2:0] cas;

  int checks = 0, fails = 0;
  logic [15:0] b_irr = '0;
  logic [7:0] mm = '0, sm = '0;
  int order [15] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};

  always #10 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .mask_we_i(mask_we), .mask_sel_i(mask_sel), .mask_i(mask_v),
    .inta_i(inta), .eoi_i(eoi), .eoi_slave_i(eoi_slave), .eoi_lvl_i(eoi_lvl),
    .int_o(int_w), .vec_o(vec), .vec_oe_o(vec_oe), .cas_o(cas)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int winner();
    for (int i = 0; i < 15; i++) begin
      int l = order[i];
      if (l < 8) begin
        if (b_irr[l] && !mm[l]) return l;
      end else begin
        if (b_irr[l] && !sm[l-8] && !mm[2]) return l;
      end
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_vec(input int l);
    if (l < 0) return {MB, 3'd7};
    if (l < 8) return {MB, 3'(l)};
    if (l == 9) return {MB, 3'd2};
    return {SB, 3'(l - 8)};
  endfunction

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk); irq = bits;
    @(negedge clk); irq = '0;
    b_irr |= bits & 16'hFFFB;
  endtask

  task automatic set_mask(input bit sel, input logic [7:0] v);
    @(negedge clk); mask_we = 1; mask_sel = sel; mask_v = v;
    @(negedge clk); mask_we = 0;
    if (sel) sm = v; else mm = v;
  endtask

  task automatic send_eoi(input bit sl, input int lvl);
    @(negedge clk); eoi = 1; eoi_slave = sl; eoi_lvl = 3'(lvl);
    @(negedge clk); eoi = 0;
  endtask

  task automatic end_src(input int l);
    if (l >= 8) begin
      send_eoi(1, l - 8);
      send_eoi(0, 2);
    end else send_eoi(0, l);
  endtask

  task automatic ack_check(input int l, input string tag);
    int ecas;
    ecas = (l < 0) ? 7 : (l < 8 ? l : 2);
    @(negedge clk); inta = 1; #1;
    chk(vec_oe == 0, "R4 no data on first strobe", vec_oe, 0);
    @(negedge clk); inta = 0;
    chk(cas == 3'(ecas), {"R2 cas ", tag}, cas, ecas);
    @(negedge clk); inta = 1; #1;
    chk(vec_oe == 1 && vec == exp_vec(l), {"R5 vector ", tag}, vec, exp_vec(l));
    @(negedge clk); inta = 0;
    chk(cas == 0, "R2 cas idle", cas, 0);
    if (l >= 0) b_irr[l] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(int_w == 0 && vec_oe == 0 && cas == 0, "R10 reset outputs", {int_w, vec_oe, cas}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: line 2 ignored
    pulse(16'h0004);
    chk(int_w == 0, "R1 line 2 ignored", int_w, 0);

    // R9: spurious acknowledge
    ack_check(-1, "R9 spurious");
    pulse(16'h0080);
    chk(int_w == 1, "R9 spurious set nothing", int_w, 1);
    ack_check(7, "level 7");
    end_src(7);

    // R6: source 9 aliases master level 2
    pulse(16'h0200);
    ack_check(9, "R6 source 9");
    end_src(9);
    chk(int_w == 0, "R8 idle after both ends", int_w, 0);

    // R7 R8: master nesting
    pulse(16'h0020);
    ack_check(5, "R7 first");
    pulse(16'h0040);
    chk(int_w == 0, "R7 lower blocked", int_w, 0);
    pulse(16'h0008);
    chk(int_w == 1, "R7 higher passes", int_w, 1);
    ack_check(3, "R7 nested");
    send_eoi(0, 3);
    chk(int_w == 0, "R8 level 5 still blocks", int_w, 0);
    send_eoi(0, 5);
    chk(int_w == 1, "R8 lower released", int_w, 1);
    ack_check(6, "R7 released");
    send_eoi(0, 6);

    // R7 R8: slave in service holds master slot 2
    pulse(16'h1000);
    ack_check(12, "slave 12");
    pulse(16'h0010);
    chk(int_w == 0, "R7 master 4 under slave", int_w, 0);
    pulse(16'h0001);
    chk(int_w == 1, "R7 master 0 over slave", int_w, 1);
    ack_check(0, "nested 0");
    send_eoi(0, 0);
    send_eoi(1, 4);
    chk(int_w == 0, "R8 slave needs master end", int_w, 0);
    send_eoi(0, 2);
    chk(int_w == 1, "R8 both ends release", int_w, 1);
    ack_check(4, "released 4");
    send_eoi(0, 4);

    // R3: masked request stays pending
    set_mask(0, 8'h02);
    pulse(16'h0002);
    chk(int_w == 0, "R3 masked", int_w, 0);
    set_mask(0, 8'h00);
    chk(int_w == 1, "R3 unmasked pending", int_w, 1);
    ack_check(1, "R3 after unmask");
    end_src(1);

    // R1: held line gives one request
    @(negedge clk); irq = 16'h0008;
    @(negedge clk);
    b_irr[3] = 1'b1;
    ack_check(3, "R1 held");
    end_src(3);
    repeat (3) @(negedge clk);
    chk(int_w == 0, "R1 held line single request", int_w, 0);
    irq = '0;
    @(negedge clk);

    // R2 R3 R5: random bursts drained in priority order
    for (int r = 0; r < 40; r++) begin
      logic [7:0] nm, ns;
      nm = 8'($urandom & $urandom);
      if ($urandom % 4 != 0) nm[2] = 1'b0;
      ns = 8'($urandom & $urandom);
      set_mask(0, nm);
      set_mask(1, ns);
      pulse(16'($urandom & $urandom | $urandom & $urandom));
      chk(int_w == (winner() >= 0), "R3 int after burst", int_w, winner() >= 0);
      for (int k = 0; k < 16; k++) begin
        int w;
        w = winner();
        if (w < 0) break;
        ack_check(w, "R2 random order");
        end_src(w);
      end
    end
    set_mask(0, 8'h00);
    set_mask(1, 8'h00);
    for (int k = 0; k < 16; k++) begin
      int w;
      w = winner();
      if (w < 0) break;
      ack_check(w, "R2 drain");
      end_src(w);
    end
    chk(int_w == 0, "R8 all ended", int_w, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule